// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Ready and Threshold Flags

This block is a 1024-word by 36-bit queue with two unrelated clocks. The write clock drives port A and the read clock drives port B. Each port takes a transfer only when it is fully qualified. Chip select and mailbox select must both be low. The direction select must point the right way. The enable must be high, and the port's own ready flag must be high. The block also produces the output-enable term that a pad ring would use for each port's data lines. The pad drivers themselves are not part of the block.

Read data is presented in fall-through style. When the output register is empty and a word sits in memory, that word moves into the register on its own and `out_valid` rises. No read request is needed for this. Every later word must be taken by a qualified read. Two threshold flags, both active low, warn of the two ends of the queue. `almost_empty_n` is computed in the read domain and `almost_full_n` in the write domain. Each is compared against an offset input.

Pointers cross between the domains in Gray code through two-flop synchronizers. Reset is asynchronous to both clocks. It is asserted at once and released separately in each domain through its own synchronizer.

The write side is a three-state machine. `WS_HOLD` is entered on reset. `WS_HOLD -> WS_ARM` happens on the first edge after the synchronized release. `WS_ARM -> WS_OPEN` happens on the next edge. `WS_OPEN` is final until reset. The read side has two states. In `RS_DRY` the output register is empty. In `RS_HELD` it holds a word. The transition `RS_DRY -> RS_HELD` is the fall-through load, taken when memory holds a word. The transition `RS_HELD -> RS_DRY` happens when a qualified read finds memory empty. `RS_HELD` stays in `RS_HELD` when a read finds memory non-empty: the next word is loaded on the same edge.

Top module: `xc_fwft_fifo`

## Requirements
- R1: A word is stored on a `wr_clk` rising edge only if `a_cs_n`=0, `a_mbox`=0, `a_dir`=1, `a_en`=1 and `in_ready`=1. Any other combination stores nothing.
- R2: A word is taken from the output register on a `rd_clk` rising edge only if `b_cs_n`=0, `b_mbox`=0, `b_dir`=1, `b_en`=1 and `out_valid`=1. Other combinations leave `b_dout` and `out_valid` unchanged. A read that empties the queue drops `out_valid` to 0.
- R3: While `out_valid`=0 and memory holds a word, that word is loaded into `b_dout` and `out_valid` rises on the same `rd_clk` edge, with no read request.
- R4: Words leave `b_dout` in the order they were written. `b_dout` holds its value while no read is taken.
- R5: `a_oe` = 1 exactly when `a_cs_n`=0 and `a_dir`=0. `b_oe` = 1 exactly when `b_cs_n`=0 and `b_dir`=1.
- R6: While `rst_n` is low, `in_ready`=0, `out_valid`=0, `almost_empty_n`=0 and `almost_full_n`=1, and both pointers are cleared.
- R7: `in_ready` rises no earlier than two `wr_clk` rising edges after `rst_n` goes high. It is 0 whenever memory holds 1024 words. Memory full plus the output register means 1025 words in the block.
- R8: `almost_empty_n` is 0 while the number of stored words, counting the output register, is at most `ae_ofs`. Otherwise it is 1.
- R9: `almost_full_n` is 0 while the number of free memory locations is at most `af_ofs`. Otherwise it is 1.
- R10: Writes and reads run independently. Concurrent streams on both ports keep every word, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Port A (write) clock |
| rd_clk | input | 1 | Port B (read) clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_dir | input | 1 | Port A direction: 1 = write into FIFO |
| a_en | input | 1 | Port A enable |
| a_mbox | input | 1 | Port A mailbox select; must be 0 for FIFO access |
| a_din | input | 36 | Write data |
| a_oe | output | 1 | Port A data output enable |
| in_ready | output | 1 | Room for a write |
| almost_full_n | output | 1 | Low when free locations are at most `af_ofs` |
| af_ofs | input | 11 | Almost-full offset |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_dir | input | 1 | Port B direction: 1 = read from FIFO |
| b_en | input | 1 | Port B enable |
| b_mbox | input | 1 | Port B mailbox select; must be 0 for FIFO access |
| b_dout | output | 36 | Output register |
| b_oe | output | 1 | Port B data output enable |
| out_valid | output | 1 | `b_dout` holds a valid word |
| almost_empty_n | output | 1 | Low when stored words are at most `ae_ofs` |
| ae_ofs | input | 11 | Almost-empty offset |

## Verification
A qualified read and the fall-through refill of the next word fall on the same `rd_clk` edge. That same edge is also while writes keep moving the write pointer across the boundary. The bench runs both ports at once, from unrelated clocks with irregular gaps on the read side. This makes refills, pointer updates and reads collide at many phase offsets. A scoreboard queue holds every accepted word. Each completed read must pop the same word, and the queue must end empty with `out_valid` low.

// File: rtl/xc_fifo_pkg.sv
package xc_fifo_pkg;

    // Write-side sequencing after reset release
    typedef enum logic [1:0] {
        WS_HOLD = 2'd0,
        WS_ARM  = 2'd1,
        WS_OPEN = 2'd2
    } wr_state_t;

    // Read-side output register occupancy
    typedef enum logic {
        RS_DRY  = 1'b0,
        RS_HELD = 1'b1
    } rd_state_t;

endpackage

// File: rtl/xc_rst_sync.sv
module xc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain_q;

    // Assert at once, release after STAGES edges of clk
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/xc_gray_sync.sv
module xc_gray_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_gray,
    output logic [W-1:0] q_gray
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_gray[i];
                sync_q <= meta_q;
            end
        end
        assign q_gray[i] = sync_q;
    end
endmodule

// File: rtl/xc_wr_side.sv
module xc_wr_side
    import xc_fifo_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_mbox,
    input  logic              a_dir,
    input  logic              a_en,
    input  logic [ADDR_W:0]   rgray_s,
    input  logic [ADDR_W:0]   af_ofs,
    output logic              wr_en,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              in_ready,
    output logic              af_n
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wr_state_t     state_q, state_nx;
    logic [PW-1:0] wbin_q, wgray_q, wbin_nx, rbin_s, used, free_loc;
    logic          full, qual;

    assign rbin_s   = g2b(rgray_s);
    assign used     = wbin_q - rbin_s;
    assign free_loc = DEPTH_P - used;
    assign full     = (wgray_q == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign qual     = !a_cs_n && !a_mbox && a_dir && a_en;
    assign wr_en    = qual && in_ready;
    assign wbin_nx  = wbin_q + 1'b1;
    assign waddr    = wbin_q[ADDR_W-1:0];
    assign wgray    = wgray_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_HOLD;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            WS_HOLD: state_nx = WS_ARM;
            WS_ARM:  state_nx = WS_OPEN;
            WS_OPEN: state_nx = WS_OPEN;
            default: state_nx = WS_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        af_n     = 1'b1;
        unique case (state_q)
            WS_OPEN: begin
                in_ready = !full;
                af_n     = (free_loc > af_ofs);
            end
            default: begin
                in_ready = 1'b0;
                af_n     = 1'b1;
            end
        endcase
    end

    // Write pointer, binary and Gray
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wr_en) begin
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // R7: ready only with room left (Gray compare vs binary count)
    a_r7_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (used < DEPTH_P));

    // R1: pointer moves only on an accepted write
    a_r1_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wbin_q));

    // R9: a full memory always shows almost-full
    a_r9_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (used == DEPTH_P) |-> !af_n);
endmodule

// File: rtl/xc_rd_side.sv
module xc_rd_side
    import xc_fifo_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              b_cs_n,
    input  logic              b_mbox,
    input  logic              b_dir,
    input  logic              b_en,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [ADDR_W:0]   ae_ofs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] dout,
    output logic              out_valid,
    output logic              ae_n
);
    localparam int PW = ADDR_W + 1;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_state_t     state_q, state_nx;
    logic [PW-1:0] rbin_q, rgray_q, rbin_nx, wbin_s, mem_cnt, total;
    logic [DATA_W-1:0] dout_q;
    logic          have, rd_req, load;

    assign wbin_s  = g2b(wgray_s);
    assign mem_cnt = wbin_s - rbin_q;
    assign have    = (mem_cnt != '0);
    assign rd_req  = !b_cs_n && !b_mbox && b_dir && b_en && out_valid;
    assign rbin_nx = rbin_q + 1'b1;
    assign raddr   = rbin_q[ADDR_W-1:0];
    assign rgray   = rgray_q;
    assign dout    = dout_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_DRY;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        load     = 1'b0;
        unique case (state_q)
            RS_DRY: begin
                if (have) begin
                    state_nx = RS_HELD;   // fall-through load
                    load     = 1'b1;
                end
            end
            RS_HELD: begin
                if (rd_req) begin
                    if (have) load = 1'b1;
                    else      state_nx = RS_DRY;
                end
            end
            default: state_nx = RS_DRY;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            RS_HELD: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
        total = mem_cnt + {{ADDR_W{1'b0}}, out_valid};
        ae_n  = (total > ae_ofs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            dout_q  <= '0;
        end else if (load) begin
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
            dout_q  <= mem_rdata;
        end
    end

    // R3: output register fills only when memory had a word
    a_r3_fill_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(have));

    // R4: word and valid hold while no read is taken
    a_r4_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !rd_req) |=> ($stable(dout) && out_valid));

    // R2: reading the last word clears valid
    a_r2_last_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !have) |=> !out_valid);
endmodule

// File: rtl/xc_fwft_fifo.sv
module xc_fwft_fifo #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_dir,
    input  logic              a_en,
    input  logic              a_mbox,
    input  logic [DATA_W-1:0] a_din,
    output logic              a_oe,
    output logic              in_ready,
    output logic              almost_full_n,
    input  logic [ADDR_W:0]   af_ofs,
    input  logic              b_cs_n,
    input  logic              b_dir,
    input  logic              b_en,
    input  logic              b_mbox,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_oe,
    output logic              out_valid,
    output logic              almost_empty_n,
    input  logic [ADDR_W:0]   ae_ofs
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic              wr_rst_n, rd_rst_n, wr_en;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] mem [DEPTH];

    assign a_oe = !a_cs_n && !a_dir;
    assign b_oe = !b_cs_n &&  b_dir;

    xc_rst_sync #(.STAGES(2)) u_wr_rst (
        .clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
    xc_rst_sync #(.STAGES(2)) u_rd_rst (
        .clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

    xc_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d_gray(rgray), .q_gray(rgray_s));
    xc_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d_gray(wgray), .q_gray(wgray_s));

    xc_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .a_cs_n(a_cs_n), .a_mbox(a_mbox), .a_dir(a_dir), .a_en(a_en),
        .rgray_s(rgray_s), .af_ofs(af_ofs),
        .wr_en(wr_en), .waddr(waddr), .wgray(wgray),
        .in_ready(in_ready), .af_n(almost_full_n));

    xc_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n),
        .b_cs_n(b_cs_n), .b_mbox(b_mbox), .b_dir(b_dir), .b_en(b_en),
        .wgray_s(wgray_s), .ae_ofs(ae_ofs), .mem_rdata(mem_rdata),
        .raddr(raddr), .rgray(rgray), .dout(b_dout),
        .out_valid(out_valid), .ae_n(almost_empty_n));

    // Storage: written in the write domain, read asynchronously by the read side
    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[waddr] <= a_din;
    end
    assign mem_rdata = mem[raddr];
endmodule

// File: tb/xc_fwft_fifo_bench.sv
module xc_fwft_fifo_bench;
    logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic        a_cs_n = 1'b1, a_dir = 1'b0, a_en = 1'b0, a_mbox = 1'b0;
    logic [35:0] a_din = '0;
    logic        b_cs_n = 1'b1, b_dir = 1'b0, b_en = 1'b0, b_mbox = 1'b0;
    logic [10:0] ae_ofs = 11'd4, af_ofs = 11'd4;
    logic        a_oe, in_ready, almost_full_n, b_oe, out_valid, almost_empty_n;
    logic [35:0] b_dout;

    logic [35:0] sb_q[$];
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    xc_fwft_fifo u_xc_fwft_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_dir(a_dir), .a_en(a_en), .a_mbox(a_mbox),
        .a_din(a_din), .a_oe(a_oe), .in_ready(in_ready),
        .almost_full_n(almost_full_n), .af_ofs(af_ofs),
        .b_cs_n(b_cs_n), .b_dir(b_dir), .b_en(b_en), .b_mbox(b_mbox),
        .b_dout(b_dout), .b_oe(b_oe), .out_valid(out_valid),
        .almost_empty_n(almost_empty_n), .ae_ofs(ae_ofs));

    task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: one qualified write, expected word pushed to scoreboard
    task automatic wr_word(input logic [35:0] d);
        @(negedge wr_clk);
        while (!in_ready) @(negedge wr_clk);
        a_cs_n = 1'b0; a_mbox = 1'b0; a_dir = 1'b1; a_en = 1'b1; a_din = d;
        sb_q.push_back(d);
        @(negedge wr_clk);
        a_en = 1'b0; a_cs_n = 1'b1;
    endtask

    // One write attempt with given qualifiers, nothing expected
    task automatic wr_try(input logic cs_n, input logic mb, input logic dir,
                          input logic en, input logic [35:0] d);
        @(negedge wr_clk);
        a_cs_n = cs_n; a_mbox = mb; a_dir = dir; a_en = en; a_din = d;
        @(negedge wr_clk);
        a_cs_n = 1'b1; a_mbox = 1'b0; a_dir = 1'b0; a_en = 1'b0;
    endtask

    task automatic rd_word();
        @(negedge rd_clk); #1;
        while (!out_valid) begin @(negedge rd_clk); #1; end
        b_cs_n = 1'b0; b_mbox = 1'b0; b_dir = 1'b1; b_en = 1'b1;
        @(negedge rd_clk); #1;
        b_en = 1'b0; b_cs_n = 1'b1;
    endtask

    task automatic rd_try(input logic cs_n, input logic mb, input logic dir,
                          input logic en);
        @(negedge rd_clk); #1;
        b_cs_n = cs_n; b_mbox = mb; b_dir = dir; b_en = en;
        @(negedge rd_clk); #1;
        b_cs_n = 1'b1; b_mbox = 1'b0; b_dir = 1'b0; b_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
        @(negedge rd_clk); #2;
    endtask

    // Monitor: every completed read must match the scoreboard head (R4, R10)
    always begin
        @(negedge rd_clk); #3;
        if (!b_cs_n && !b_mbox && b_dir && b_en && out_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R4 read with empty scoreboard", b_dout, 0);
            end else begin
                logic [35:0] e;
                e = sb_q.pop_front();
                chk(b_dout == e, "R4 order", b_dout, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int edges;
        logic [35:0] w0;
        // R6 reset state
        repeat (6) @(negedge wr_clk);
        chk(in_ready == 1'b0, "R6 in_ready", in_ready, 0);
        chk(out_valid == 1'b0, "R6 out_valid", out_valid, 0);
        chk(almost_empty_n == 1'b0, "R6 almost_empty_n", almost_empty_n, 0);
        chk(almost_full_n == 1'b1, "R6 almost_full_n", almost_full_n, 1);

        // R5 output enables
        for (int k = 0; k < 4; k++) begin
            a_cs_n = k[1]; a_dir = k[0]; b_cs_n = k[1]; b_dir = k[0];
            #1;
            chk(a_oe == (!k[1] && !k[0]), "R5 a_oe", a_oe, (!k[1] && !k[0]));
            chk(b_oe == (!k[1] && k[0]), "R5 b_oe", b_oe, (!k[1] && k[0]));
        end
        a_cs_n = 1'b1; a_dir = 1'b0; b_cs_n = 1'b1; b_dir = 1'b0;

        // R7 ready delay after reset release
        @(negedge wr_clk);
        rst_n = 1'b1;
        edges = 0;
        while (!in_ready && edges < 50) begin @(negedge wr_clk); edges++; end
        chk(edges >= 2 && in_ready, "R7 ready delay", edges, 2);

        // R1 unqualified writes ignored
        wr_try(1'b1, 1'b0, 1'b1, 1'b1, 36'h111111111);
        wr_try(1'b0, 1'b1, 1'b1, 1'b1, 36'h222222222);
        wr_try(1'b0, 1'b0, 1'b0, 1'b1, 36'h333333333);
        wr_try(1'b0, 1'b0, 1'b1, 1'b0, 36'h444444444);
        settle();
        chk(out_valid == 1'b0, "R1 ignored writes", out_valid, 0);

        // R3 fall-through of first word
        w0 = 36'hA5A5_0C3F_1;
        wr_word(w0);
        settle();
        chk(out_valid == 1'b1, "R3 out_valid", out_valid, 1);
        chk(b_dout == w0, "R3 word", b_dout, w0);
        chk(almost_empty_n == 1'b0, "R8 one word", almost_empty_n, 0);

        // R2 unqualified reads ignored
        rd_try(1'b1, 1'b0, 1'b1, 1'b1);
        rd_try(1'b0, 1'b1, 1'b1, 1'b1);
        rd_try(1'b0, 1'b0, 1'b0, 1'b1);
        rd_try(1'b0, 1'b0, 1'b1, 1'b0);
        settle();
        chk(out_valid == 1'b1, "R2 valid kept", out_valid, 1);
        chk(b_dout == w0, "R2 word kept", b_dout, w0);
        rd_word();
        settle();
        chk(out_valid == 1'b0, "R2 last read clears", out_valid, 0);

        // R8 almost-empty threshold (ae_ofs = 4)
        for (int i = 0; i < 4; i++) wr_word({4'h1, 32'(i)});
        settle();
        chk(almost_empty_n == 1'b0, "R8 four words", almost_empty_n, 0);
        wr_word({4'h1, 32'd4});
        settle();
        chk(almost_empty_n == 1'b1, "R8 five words", almost_empty_n, 1);

        // R9 almost-full threshold (af_ofs = 4); one word sits in output register
        for (int i = 5; i < 1020; i++) wr_word({4'h2, 32'(i)});
        settle();
        chk(almost_full_n == 1'b1, "R9 five free", almost_full_n, 1);
        chk(in_ready == 1'b1, "R7 room left", in_ready, 1);
        wr_word({4'h2, 32'd1020});
        settle();
        chk(almost_full_n == 1'b0, "R9 four free", almost_full_n, 0);
        for (int i = 1021; i < 1025; i++) wr_word({4'h2, 32'(i)});
        settle();
        chk(in_ready == 1'b0, "R7 full", in_ready, 0);
        chk(almost_full_n == 1'b0, "R9 full", almost_full_n, 0);

        // R1 write while full must be dropped
        wr_try(1'b0, 1'b0, 1'b1, 1'b1, 36'hDEADBEEF0);

        // Drain all; monitor checks order
        for (int i = 0; i < 1025; i++) rd_word();
        settle();
        chk(out_valid == 1'b0, "R1 full write dropped", out_valid, 0);
        chk(sb_q.size() == 0, "R4 drained", sb_q.size(), 0);
        chk(almost_empty_n == 1'b0, "R8 empty", almost_empty_n, 0);
        chk(almost_full_n == 1'b1, "R9 empty", almost_full_n, 1);

        // R10 concurrent streams with irregular read gaps
        fork
            begin
                for (int i = 0; i < 300; i++) wr_word({4'h3, 32'(i * 7 + 1)});
            end
            begin
                logic [7:0] lf = 8'h5B;
                for (int i = 0; i < 300; i++) begin
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    repeat (int'(lf[1:0])) @(negedge rd_clk);
                    rd_word();
                end
            end
        join
        settle();
        chk(sb_q.size() == 0, "R10 all words read", sb_q.size(), 0);
        chk(out_valid == 1'b0, "R10 empty after stream", out_valid, 0);

        finish_run();
    end
endmodule